// File: doc/BRIEF.md
# Triggered Record Length Controller

This block decides how long a triggered acquisition runs and tells the host what happened. When the host starts a run, a sample address counter advances on every conversion tick until it has collected the requested number of pre-trigger samples. Only then is the trigger input armed. An accepted trigger is held until the next conversion tick, and that tick raises a delayed-trigger level. This level enables a record counter, which was preloaded when the run started.

The record counter advances once per record tick. When it wraps past its all-ones value, end-of-record rises and the run stops. The run stays stopped until the host starts a new one. There are three interrupt causes: record complete, byte pair acquired and trigger accepted. Each cause has its own enable. The host learns which cause fired by reading a status word, and the read clears it.

The host sets the number of record ticks in the post-trigger phase through the preload. With a counter of REC_W bits and a preload value L, the record ends on tick number 2^REC_W − L.

Top module: `acq_rec_top`

## Requirements
- R1: A start pulse aborts any run in progress and captures the pre-trigger count and the record preload. In the following cycle `acquiring` is high, and `trigDelayed`, `endOfRecord` and `armed` are low. The exception is a pre-trigger count of zero, where `armed` is already high in that cycle.
- R2: With a pre-trigger count P > 0, `armed` rises in the cycle after the P-th conversion tick of the run, and not before. Of `armed`, `trigDelayed` and `endOfRecord`, at most one is high at any time.
- R3: A trigger seen while `armed` is low has no effect. It does not advance the run and does not set the trigger cause.
- R4: An accepted trigger drops `armed`. `trigDelayed` rises in the cycle after the first conversion tick that comes later than the trigger, and not sooner.
- R5: Record ticks are counted only while `trigDelayed` is high. With preload L, `endOfRecord` rises in the cycle after record tick number 2^REC_W − L, and at that point `acquiring` and `trigDelayed` fall.
- R6: Once `endOfRecord` is high, it stays high and the run stays stopped until the next start pulse. Conversion ticks, record ticks and triggers are ignored until then.
- R7: `statusOut` bit 0 is record complete, bit 1 is byte pair acquired and bit 2 is trigger accepted. A cause is latched only if its `irqEn` bit is set in the cycle of the event. A pair tick counts only while `acquiring` is high.
- R8: `irq` is high exactly when some `statusOut` bit is set and its `irqEn` bit is also set.
- R9: A `statusRead` pulse clears all latched causes. A cause whose event arrives in the same cycle as the read stays latched.
- R10: After a restart, the record counter counts from the new preload. No state from the aborted run carries over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startAcq | input | 1 | Start-of-run pulse |
| pretrigCount | input | ADDR_W | Number of pre-trigger samples, sampled at start |
| recPreload | input | REC_W | Record counter preload, sampled at start |
| convTick | input | 1 | Conversion clock strobe |
| recTick | input | 1 | Record clock strobe |
| trigIn | input | 1 | Trigger input |
| pairTick | input | 1 | Byte pair acquired strobe |
| irqEn | input | 3 | Per-cause interrupt enables |
| statusRead | input | 1 | Host status read pulse (clears causes) |
| statusOut | output | 3 | Latched interrupt causes |
| irq | output | 1 | Interrupt request |
| acquiring | output | 1 | Run in progress |
| armed | output | 1 | Trigger input armed |
| trigDelayed | output | 1 | Conversion-aligned delayed trigger |
| endOfRecord | output | 1 | Record counter overflowed |

## Verification
The assertions check, on every cycle, the properties that hold at any instant:
- `trigDelayed` only ever rises right after a conversion tick.
- End-of-record only rises on a record tick taken while `trigDelayed` is high.
- End-of-record holds until a new start.
- The three phase flags are mutually exclusive.
- A disabled cause never appears.
- A read with no events clears the status.
- `irq` is low whenever no cause is latched.

The exact counts can only be shown by the bench scenarios:
- that arming happens on the P-th conversion tick;
- that the record ends on tick 2^REC_W − L;
- that triggers and record ticks before the proper phase are ignored;
- that a restart reloads the counters.

// File: rtl/acq_rec_pkg.sv
package acq_rec_pkg;
  localparam int CAUSE_W   = 3;
  localparam int CAUSE_REC  = 0;
  localparam int CAUSE_PAIR = 1;
  localparam int CAUSE_TRIG = 2;

  typedef enum logic [2:0] {
    S_IDLE, S_FILL, S_ARMED, S_TDLY, S_REC, S_DONE
  } acqState_t;

  typedef struct packed {
    logic load;       // capture preloads, clear counters
    logic addrInc;    // advance pre-trigger address counter
    logic recInc;     // advance record counter
    logic trigEvt;    // trigger accepted this cycle
    logic recEvt;     // record counter overflowed this cycle
    logic acqActive;  // a run is in progress
  } ctrlStrobe_t;
endpackage

// File: rtl/acq_rec_ctrl.sv
module acq_rec_ctrl
  import acq_rec_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startAcq,
  input  logic        startZero,
  input  logic        convTick,
  input  logic        recTick,
  input  logic        trigIn,
  input  logic        addrHit,
  input  logic        recAtMax,
  output ctrlStrobe_t strobe,
  output logic        acquiring,
  output logic        armed,
  output logic        trigDelayed,
  output logic        endOfRecord
);
  acqState_t state, stateNext;

  always_comb begin
    stateNext = state;
    if (startAcq) begin
      stateNext = startZero ? S_ARMED : S_FILL;
    end else begin
      unique case (state)
        S_FILL:  if (convTick && addrHit)  stateNext = S_ARMED;
        S_ARMED: if (trigIn)               stateNext = S_TDLY;
        S_TDLY:  if (convTick)             stateNext = S_REC;
        S_REC:   if (recTick && recAtMax)  stateNext = S_DONE;
        default: stateNext = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe           = '0;
    strobe.load      = startAcq;
    strobe.addrInc   = !startAcq && (state == S_FILL) && convTick;
    strobe.recInc    = !startAcq && (state == S_REC) && recTick && !recAtMax;
    strobe.trigEvt   = !startAcq && (state == S_ARMED) && trigIn;
    strobe.recEvt    = !startAcq && (state == S_REC) && recTick && recAtMax;
    strobe.acqActive = acquiring;
  end

  assign acquiring   = (state == S_FILL) || (state == S_ARMED) ||
                       (state == S_TDLY) || (state == S_REC);
  assign armed       = (state == S_ARMED);
  assign trigDelayed = (state == S_REC);
  assign endOfRecord = (state == S_DONE);
endmodule

// File: rtl/acq_rec_dpath.sv
module acq_rec_dpath
  import acq_rec_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int REC_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic [ADDR_W-1:0]  pretrigCount,
  input  logic [REC_W-1:0]   recPreload,
  input  logic               pairTick,
  input  logic [CAUSE_W-1:0] irqEn,
  input  logic               statusRead,
  output logic               startZero,
  output logic               addrHit,
  output logic               recAtMax,
  output logic [CAUSE_W-1:0] statusOut,
  output logic               irq
);
  localparam logic [REC_W-1:0] REC_MAX = {REC_W{1'b1}};

  logic [ADDR_W-1:0]  pretrigReg, addrCount, addrNext;
  logic [REC_W-1:0]   recCount;
  logic [CAUSE_W-1:0] pending, newEvt;

  assign addrNext  = addrCount + ADDR_W'(1);
  assign addrHit   = (addrNext == pretrigReg);
  assign recAtMax  = (recCount == REC_MAX);
  assign startZero = (pretrigCount == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pretrigReg <= '0;
      addrCount  <= '0;
      recCount   <= '0;
    end else if (strobe.load) begin
      pretrigReg <= pretrigCount;
      addrCount  <= '0;
      recCount   <= recPreload;
    end else begin
      if (strobe.addrInc) addrCount <= addrNext;
      if (strobe.recInc)  recCount  <= recCount + REC_W'(1);
    end
  end

  always_comb begin
    newEvt             = '0;
    newEvt[CAUSE_REC]  = strobe.recEvt;
    newEvt[CAUSE_PAIR] = pairTick && strobe.acqActive;
    newEvt[CAUSE_TRIG] = strobe.trigEvt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pending <= '0;
    else       pending <= (statusRead ? '0 : pending) | (newEvt & irqEn);
  end

  assign statusOut = pending;
  assign irq       = |(pending & irqEn);
endmodule

// File: rtl/acq_rec_top.sv
module acq_rec_top
  import acq_rec_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int REC_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startAcq,
  input  logic [ADDR_W-1:0]  pretrigCount,
  input  logic [REC_W-1:0]   recPreload,
  input  logic               convTick,
  input  logic               recTick,
  input  logic               trigIn,
  input  logic               pairTick,
  input  logic [CAUSE_W-1:0] irqEn,
  input  logic               statusRead,
  output logic [CAUSE_W-1:0] statusOut,
  output logic               irq,
  output logic               acquiring,
  output logic               armed,
  output logic               trigDelayed,
  output logic               endOfRecord
);
  ctrlStrobe_t strobe;
  logic startZero, addrHit, recAtMax;

  acq_rec_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startAcq(startAcq), .startZero(startZero),
    .convTick(convTick), .recTick(recTick), .trigIn(trigIn),
    .addrHit(addrHit), .recAtMax(recAtMax), .strobe(strobe),
    .acquiring(acquiring), .armed(armed), .trigDelayed(trigDelayed),
    .endOfRecord(endOfRecord)
  );

  acq_rec_dpath #(.ADDR_W(ADDR_W), .REC_W(REC_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pretrigCount(pretrigCount),
    .recPreload(recPreload), .pairTick(pairTick), .irqEn(irqEn),
    .statusRead(statusRead), .startZero(startZero), .addrHit(addrHit),
    .recAtMax(recAtMax), .statusOut(statusOut), .irq(irq)
  );
endmodule

// File: rtl/acq_rec_chk.sv
module acq_rec_chk
  import acq_rec_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               startAcq,
  input logic               convTick,
  input logic               recTick,
  input logic               trigIn,
  input logic               pairTick,
  input logic [CAUSE_W-1:0] irqEn,
  input logic               statusRead,
  input logic [CAUSE_W-1:0] statusOut,
  input logic               irq,
  input logic               acquiring,
  input logic               armed,
  input logic               trigDelayed,
  input logic               endOfRecord
);
  p_phase_excl_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({armed, trigDelayed, endOfRecord}));

  p_armed_running_r3: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> acquiring);

  p_conv_aligned_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(trigDelayed) |-> $past(convTick));

  p_end_on_tick_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(endOfRecord) |-> ($past(recTick) && $past(trigDelayed)));

  p_end_holds_r6: assert property (@(posedge clk) disable iff (!rstN)
    (endOfRecord && !startAcq) |=> endOfRecord);

  p_rec_gate_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!irqEn[CAUSE_REC] && !statusOut[CAUSE_REC]) |=> !statusOut[CAUSE_REC]);

  p_pair_gate_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!irqEn[CAUSE_PAIR] && !statusOut[CAUSE_PAIR]) |=> !statusOut[CAUSE_PAIR]);

  p_trig_gate_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!irqEn[CAUSE_TRIG] && !statusOut[CAUSE_TRIG]) |=> !statusOut[CAUSE_TRIG]);

  p_quiet_irq_r8: assert property (@(posedge clk) disable iff (!rstN)
    (statusOut == '0) |-> !irq);

  p_read_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    (statusRead && !pairTick && !trigIn && !recTick) |=> (statusOut == '0));
endmodule

bind acq_rec_top acq_rec_chk u_chk (
  .clk(clk), .rstN(rstN), .startAcq(startAcq), .convTick(convTick),
  .recTick(recTick), .trigIn(trigIn), .pairTick(pairTick), .irqEn(irqEn),
  .statusRead(statusRead), .statusOut(statusOut), .irq(irq),
  .acquiring(acquiring), .armed(armed), .trigDelayed(trigDelayed),
  .endOfRecord(endOfRecord)
);

// File: tb/acq_rec_top_tb.sv
module acq_rec_top_tb;
  localparam int ADDR_W = 10;
  localparam int REC_W  = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startAcq = 1'b0;
  logic [ADDR_W-1:0] pretrigCount = '0;
  logic [REC_W-1:0]  recPreload = '0;
  logic convTick = 1'b0, recTick = 1'b0, trigIn = 1'b0, pairTick = 1'b0;
  logic [2:0] irqEn = '0;
  logic statusRead = 1'b0;
  logic [2:0] statusOut;
  logic irq, acquiring, armed, trigDelayed, endOfRecord;
  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  acq_rec_top #(.ADDR_W(ADDR_W), .REC_W(REC_W)) u_dut (
    .clk(clk), .rstN(rstN), .startAcq(startAcq), .pretrigCount(pretrigCount),
    .recPreload(recPreload), .convTick(convTick), .recTick(recTick),
    .trigIn(trigIn), .pairTick(pairTick), .irqEn(irqEn),
    .statusRead(statusRead), .statusOut(statusOut), .irq(irq),
    .acquiring(acquiring), .armed(armed), .trigDelayed(trigDelayed),
    .endOfRecord(endOfRecord)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // inputs change at a falling edge, are taken at the next rising edge,
  // and results are read at the falling edge after that
  task automatic drive(input logic c, input logic r, input logic t,
                       input logic p, input logic s);
    convTick = c; recTick = r; trigIn = t; pairTick = p; statusRead = s;
    @(negedge clk);
    convTick = 0; recTick = 0; trigIn = 0; pairTick = 0; statusRead = 0;
  endtask

  task automatic startRun(input int pre, input int load);
    pretrigCount = ADDR_W'(pre);
    recPreload   = REC_W'(load);
    startAcq     = 1'b1;
    @(negedge clk);
    startAcq     = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 reset acquiring", acquiring, 0);
    chk("R1 reset armed", armed, 0);
    chk("R6 reset endOfRecord", endOfRecord, 0);
    chk("R8 reset irq", irq, 0);
    chk("R7 reset status", statusOut, 0);
  endtask

  task automatic t_full_run;
    irqEn = 3'b111;
    startRun(3, 252);
    chk("R1 acquiring after start", acquiring, 1);
    chk("R1 armed low after start", armed, 0);
    drive(1, 0, 0, 0, 0);
    drive(1, 0, 0, 0, 0);
    chk("R2 not armed after 2 of 3", armed, 0);
    drive(0, 0, 1, 0, 0);
    chk("R3 early trigger armed", armed, 0);
    chk("R3 early trigger cause", statusOut[2], 0);
    drive(1, 0, 0, 0, 0);
    chk("R2 armed after 3rd tick", armed, 1);
    drive(0, 1, 0, 0, 0);
    drive(0, 0, 1, 0, 0);
    chk("R4 armed drops on trigger", armed, 0);
    chk("R4 no delayed trigger yet", trigDelayed, 0);
    chk("R7 trigger cause", statusOut, 3'b100);
    chk("R8 irq on trigger", irq, 1);
    drive(0, 1, 0, 0, 0);
    chk("R4 record tick does not align", trigDelayed, 0);
    drive(1, 0, 0, 0, 0);
    chk("R4 delayed trigger on conv", trigDelayed, 1);
    for (int i = 0; i < 3; i++) drive(0, 1, 0, 0, 0);
    chk("R5 not done after 3 of 4", endOfRecord, 0);
    drive(0, 1, 0, 0, 0);
    chk("R5 end after 4 ticks", endOfRecord, 1);
    chk("R5 acquiring stops", acquiring, 0);
    chk("R5 delayed trigger falls", trigDelayed, 0);
    chk("R7 record cause", statusOut, 3'b101);
    for (int i = 0; i < 3; i++) drive(1, 1, 1, 1, 0);
    chk("R6 end holds", endOfRecord, 1);
    chk("R6 stays stopped", acquiring, 0);
    chk("R7 no pair cause when idle", statusOut, 3'b101);
    drive(0, 0, 0, 0, 1);
    chk("R9 read clears", statusOut, 0);
    chk("R8 irq clears", irq, 0);
  endtask

  task automatic t_zero_pretrig;
    irqEn = 3'b111;
    startRun(0, 255);
    chk("R1 zero pretrigger armed", armed, 1);
    drive(0, 0, 1, 0, 0);
    drive(1, 0, 0, 0, 0);
    chk("R4 delayed trigger", trigDelayed, 1);
    drive(0, 1, 0, 0, 0);
    chk("R5 single tick preload max", endOfRecord, 1);
    drive(0, 0, 0, 0, 1);
  endtask

  task automatic t_enables;
    irqEn = 3'b010;
    startRun(4, 0);
    drive(0, 0, 0, 1, 0);
    chk("R7 pair cause", statusOut, 3'b010);
    chk("R8 irq pair", irq, 1);
    irqEn = 3'b000;
    #1;
    chk("R8 irq masked", irq, 0);
    chk("R8 cause kept", statusOut, 3'b010);
    irqEn = 3'b010;
    drive(0, 0, 0, 1, 1);
    chk("R9 same-cycle event survives", statusOut, 3'b010);
    drive(0, 0, 0, 0, 1);
    chk("R9 read clears pair", statusOut, 0);
    irqEn = 3'b000;
    drive(0, 0, 0, 1, 0);
    chk("R7 disabled pair ignored", statusOut, 0);
  endtask

  task automatic t_restart;
    irqEn = 3'b111;
    startRun(1, 250);
    drive(1, 0, 0, 0, 0);
    drive(0, 0, 1, 0, 0);
    drive(1, 0, 0, 0, 0);
    drive(0, 1, 0, 0, 0);
    drive(0, 1, 0, 0, 0);
    startRun(2, 254);
    chk("R10 restart acquiring", acquiring, 1);
    chk("R10 restart clears delayed", trigDelayed, 0);
    chk("R10 restart not armed", armed, 0);
    chk("R1 restart no end", endOfRecord, 0);
    drive(1, 0, 0, 0, 0);
    drive(1, 0, 0, 0, 0);
    chk("R2 armed after 2", armed, 1);
    drive(0, 0, 1, 0, 0);
    drive(1, 0, 0, 0, 0);
    drive(0, 1, 0, 0, 0);
    chk("R10 fresh preload not done", endOfRecord, 0);
    drive(0, 1, 0, 0, 0);
    chk("R10 fresh preload done", endOfRecord, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_run();
    t_zero_pretrig();
    t_enables();
    t_restart();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule